// File: doc/BRIEF.md
# Compare and branch-if-unequal unit

This unit executes the three-byte compare-and-jump-if-not-equal instruction family of a small 8-bit controller core. The sequencer pulses a start strobe and presents the opcode, the two bytes that follow it, the accumulator and the address of the instruction. The unit fetches any operand it needs through a synchronous read port into the register/RAM space. It compares the two unsigned bytes and reports the carry, whether the branch is taken, and the next program counter.

The first operand is the accumulator for the two accumulator forms. For the register and indirect forms it is the byte read from memory, and the second operand is the immediate byte or the directly addressed byte. Every form advances the program counter past its three bytes. A mismatch then adds the sign-extended third byte. Neither operand is written; the unit has no write path.

Top module: `cjne_unit`

## Requirements
- R1: After reset, busy_o, done_o, taken_o and carry_o are 0 and pc_next_o is 0.
- R2: Operand selection by opcode: 0xB4 compares acc_i with byte1_i. 0xB5 compares acc_i with RAM[byte1_i]. 0xB8..0xBF compare RAM[opcode[2:0]] with byte1_i. 0xB6/0xB7 compare RAM[RAM[opcode[0]]] with byte1_i. Reads use a port that returns the data one cycle after rd_en_o.
- R3: carry_o is 1 when the first operand is unsigned-less than the second and 0 otherwise, so a set carry always comes with a taken branch.
- R4: When the operands differ, taken_o is 1 and pc_next_o = pc_i + 3 + sign-extended byte2_i, modulo 2^16.
- R5: When the operands are equal, taken_o is 0 and pc_next_o = pc_i + 3.
- R6: done_o is a one-cycle pulse. It is first seen 1 cycle after the start cycle for 0xB4, 2 cycles after for 0xB5 and 0xB8..0xBF, and 3 cycles after for 0xB6/0xB7.
- R7: A start with an opcode outside 0xB4..0xBF starts nothing: busy_o stays 0, no done_o follows, and the outputs keep their values.
- R8: A start while busy_o is 1 is ignored, and the instruction in progress completes with its own operands.
- R9: pc_next_o, taken_o and carry_o hold their values between done_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an instruction |
| opcode_i | input | 8 | Instruction opcode |
| byte1_i | input | 8 | Second instruction byte (direct address or immediate) |
| byte2_i | input | 8 | Third instruction byte (signed displacement) |
| pc_i | input | 16 | Address of the instruction |
| acc_i | input | 8 | Accumulator value |
| rd_en_o | output | 1 | Read request to register/RAM space |
| rd_addr_o | output | 8 | Read address |
| rd_data_i | input | 8 | Read data, valid the cycle after rd_en_o |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Result valid pulse |
| taken_o | output | 1 | Branch taken |
| carry_o | output | 1 | Carry result |
| pc_next_o | output | 16 | Next program counter |

## Verification
The hardest case to reach is the indirect form, where the pointer read in the first fetch cycle becomes the address of the second fetch. The bench preloads its RAM model with pointers that land on both low and high addresses, including pointers that refer back to the pointer registers themselves. It also lands a second start strobe inside that three-cycle window. Wrap-around of the target is reached by placing instructions near 0xFFFF with positive displacements, and near 0x0000 with negative ones.

// File: rtl/cjne_pkg.sv
package cjne_pkg;
  typedef enum logic [2:0] {
    K_NONE,
    K_ACC_IMM,
    K_ACC_DIR,
    K_REG_IMM,
    K_IND_IMM
  } cjne_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH1,
    ST_FETCH2,
    ST_EXEC
  } cjne_state_e;
endpackage

// File: rtl/cjne_decode.sv
module cjne_decode #(
  parameter int OP_W  = 8,
  parameter int IDX_W = 3
) (
  input  logic [OP_W-1:0]     opcode_i,
  output cjne_pkg::cjne_kind_e kind_o,
  output logic [IDX_W-1:0]    idx_o
);
  import cjne_pkg::*;

  always_comb begin
    kind_o = K_NONE;
    idx_o  = opcode_i[IDX_W-1:0];
    if (opcode_i[OP_W-1:3] == 5'b10111) begin
      kind_o = K_REG_IMM;
    end else if (opcode_i[OP_W-1:2] == 6'b101101) begin
      unique case (opcode_i[1:0])
        2'b00:   kind_o = K_ACC_IMM;
        2'b01:   kind_o = K_ACC_DIR;
        default: begin
          kind_o = K_IND_IMM;
          idx_o  = {{(IDX_W-1){1'b0}}, opcode_i[0]};
        end
      endcase
    end
  end
endmodule

// File: rtl/cjne_cmp.sv
module cjne_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] first_i,
  input  logic [DATA_W-1:0] second_i,
  output logic              ne_o,
  output logic              lt_o
);
  logic [DATA_W:0] diff;

  // borrow out of first - second gives unsigned less-than
  always_comb begin
    diff = {1'b0, first_i} - {1'b0, second_i};
    lt_o = diff[DATA_W];
    ne_o = |(first_i ^ second_i);
  end
endmodule

// File: rtl/cjne_target.sv
module cjne_target #(
  parameter int PC_W      = 16,
  parameter int DATA_W    = 8,
  parameter int INSTR_LEN = 3
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] rel_i,
  input  logic              taken_i,
  output logic [PC_W-1:0]   pc_next_o
);
  localparam logic [PC_W-1:0] ADV = PC_W'(INSTR_LEN);

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] rel_ext;

  generate
    if (PC_W > DATA_W) begin : g_sext
      assign rel_ext = {{(PC_W-DATA_W){rel_i[DATA_W-1]}}, rel_i};
    end else begin : g_trunc
      assign rel_ext = rel_i[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    seq_pc    = pc_i + ADV;
    pc_next_o = taken_i ? (seq_pc + rel_ext) : seq_pc;
  end
endmodule

// File: rtl/cjne_unit.sv
module cjne_unit #(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [DATA_W-1:0] byte1_i,
  input  logic [DATA_W-1:0] byte2_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              taken_o,
  output logic              carry_o,
  output logic [PC_W-1:0]   pc_next_o
);
  import cjne_pkg::*;

  localparam int IDX_W     = 3;
  localparam int INSTR_LEN = 3;

  cjne_kind_e       dec_kind, kind_q;
  logic [IDX_W-1:0] dec_idx, idx_q;
  cjne_state_e      st_q, st_d;
  logic [DATA_W-1:0] b1_q, rel_q, acc_q;
  logic [PC_W-1:0]  pc_q;
  logic [DATA_W-1:0] first, second;
  logic              ne, lt;
  logic [PC_W-1:0]  tgt;
  logic              accept;

  cjne_decode #(.OP_W(8), .IDX_W(IDX_W)) u_dec (
    .opcode_i (opcode_i),
    .kind_o   (dec_kind),
    .idx_o    (dec_idx)
  );

  assign accept = start_i && (st_q == ST_IDLE) && (dec_kind != K_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= K_NONE;
      idx_q  <= '0;
      b1_q   <= '0;
      rel_q  <= '0;
      acc_q  <= '0;
      pc_q   <= '0;
    end else if (accept) begin
      kind_q <= dec_kind;
      idx_q  <= dec_idx;
      b1_q   <= byte1_i;
      rel_q  <= byte2_i;
      acc_q  <= acc_i;
      pc_q   <= pc_i;
    end
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (accept) st_d = (dec_kind == K_ACC_IMM) ? ST_EXEC : ST_FETCH1;
      ST_FETCH1: st_d = (kind_q == K_IND_IMM) ? ST_FETCH2 : ST_EXEC;
      ST_FETCH2: st_d = ST_EXEC;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // fetch 1: direct address or register index; fetch 2: pointer just read
  always_comb begin
    rd_en_o   = (st_q == ST_FETCH1) || (st_q == ST_FETCH2);
    rd_addr_o = '0;
    if (st_q == ST_FETCH1) begin
      if (kind_q == K_ACC_DIR) rd_addr_o = ADDR_W'(b1_q);
      else                     rd_addr_o = ADDR_W'(idx_q);
    end else if (st_q == ST_FETCH2) begin
      rd_addr_o = ADDR_W'(rd_data_i);
    end
  end

  always_comb begin
    first  = rd_data_i;
    second = b1_q;
    if (kind_q == K_ACC_IMM || kind_q == K_ACC_DIR) first = acc_q;
    if (kind_q == K_ACC_DIR) second = rd_data_i;
    if (kind_q == K_ACC_IMM) second = b1_q;
  end

  cjne_cmp #(.DATA_W(DATA_W)) u_cmp (
    .first_i  (first),
    .second_i (second),
    .ne_o     (ne),
    .lt_o     (lt)
  );

  cjne_target #(.PC_W(PC_W), .DATA_W(DATA_W), .INSTR_LEN(INSTR_LEN)) u_tgt (
    .pc_i      (pc_q),
    .rel_i     (rel_q),
    .taken_i   (ne),
    .pc_next_o (tgt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      taken_o   <= 1'b0;
      carry_o   <= 1'b0;
      pc_next_o <= '0;
    end else begin
      done_o <= (st_q == ST_EXEC);
      if (st_q == ST_EXEC) begin
        taken_o   <= ne;
        carry_o   <= lt;
        pc_next_o <= tgt;
      end
    end
  end

  assign busy_o = (st_q != ST_IDLE);

  assert_carry_implies_taken_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && carry_o |-> taken_o);

  assert_seq_pc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !taken_o |-> pc_next_o == pc_q + PC_W'(INSTR_LEN));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_read_when_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> busy_o);

  assert_bad_op_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && dec_kind == K_NONE) |=> !busy_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(pc_next_o) && $stable(carry_o) && $stable(taken_o));
endmodule

// File: tb/cjne_unit_tb.sv
module cjne_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0, b1 = '0, b2 = '0, acc = '0;
  logic [15:0] pc = '0;
  logic        rd_en, busy, done, taken, carry;
  logic [7:0]  rd_addr;
  logic [7:0]  rd_data = '0;
  logic [15:0] pc_next;
  logic [7:0]  mem [256];
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  cjne_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .byte1_i(b1), .byte2_i(b2), .pc_i(pc), .acc_i(acc),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .busy_o(busy), .done_o(done), .taken_o(taken), .carry_o(carry),
    .pc_next_o(pc_next)
  );

  always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] op, input logic [7:0] x1,
                        input logic [7:0] x2, input logic [15:0] p,
                        input logic [7:0] a, input string req);
    logic [7:0] f, s;
    int exp_lat, lat;
    logic [15:0] exp_pc;
    if (op == 8'hB4) begin f = a; s = x1; exp_lat = 1; end
    else if (op == 8'hB5) begin f = a; s = mem[x1]; exp_lat = 2; end
    else if (op[7:3] == 5'b10111) begin f = mem[{5'b0, op[2:0]}]; s = x1; exp_lat = 2; end
    else begin f = mem[mem[{7'b0, op[0]}]]; s = x1; exp_lat = 3; end
    exp_pc = p + 16'd3;
    if (f != s) exp_pc = exp_pc + {{8{x2[7]}}, x2};
    opcode = op; b1 = x1; b2 = x2; pc = p; acc = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 10) begin @(negedge clk); lat++; end
    chk(lat == exp_lat, "R6", "latency", lat, exp_lat);
    chk(carry == (f < s), {req, "/R3"}, "carry", int'(carry), int'(f < s));
    if (f != s) begin
      chk(taken == 1'b1, {req, "/R4"}, "taken", int'(taken), 1);
      chk(pc_next == exp_pc, {req, "/R4"}, "pc_next", int'(pc_next), int'(exp_pc));
    end else begin
      chk(taken == 1'b0, {req, "/R5"}, "taken", int'(taken), 0);
      chk(pc_next == exp_pc, {req, "/R5"}, "pc_next", int'(pc_next), int'(exp_pc));
    end
    @(negedge clk);
    chk(!done, "R6", "done pulse width", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] hold_pc;
    logic        hold_c, hold_t;
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(!busy && !done && !taken && !carry && pc_next == 16'h0, "R1", "reset state",
        {busy, done, taken, carry}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 accumulator vs immediate sweep
    for (int a = 0; a < 256; a += 17)
      for (int v = 0; v < 256; v++)
        run_op(8'hB4, 8'(v), 8'(v ^ a), 16'(a * 251 + v * 7), 8'(a), "R2 acc-imm");

    // R2 accumulator vs direct byte
    for (int d = 0; d < 256; d += 5)
      for (int a = 0; a < 256; a += 51)
        run_op(8'hB5, 8'(d), 8'(d + a), 16'(d * 300), (a == 102) ? mem[d] : 8'(a), "R2 acc-dir");

    // R2 register vs immediate
    for (int n = 0; n < 8; n++) begin
      mem[n] = 8'(n * 31 + 3);
      for (int v = 0; v < 256; v += 3)
        run_op(8'(8'hB8 + n), 8'(v), 8'(v * 5), 16'(16'hFF00 + v), 8'hA5, "R2 reg-imm");
      run_op(8'(8'hB8 + n), mem[n], 8'h40, 16'h1234, 8'h00, "R2 reg-imm equal");
    end

    // R2 indirect vs immediate, pointers incl. self-reference
    for (int i = 0; i < 2; i++)
      for (int p = 0; p < 256; p += 9) begin
        mem[i] = 8'(p);
        if (p > 1) mem[p] = 8'(p ^ 8'h5A);
        run_op(8'(8'hB6 + i), 8'(p ^ 8'h5A), 8'hF0, 16'(p * 13), 8'h00, "R2 ind-imm");
        run_op(8'(8'hB6 + i), 8'(p * 3), 8'h10, 16'(p * 13), 8'h00, "R2 ind-imm");
      end

    // R3 R4: register 7 = 0x56 against 0x60
    mem[7] = 8'h56;
    run_op(8'hBF, 8'h60, 8'h08, 16'h0100, 8'h00, "R3 example");
    chk(pc_next == 16'h010B, "R4", "example target", int'(pc_next), 16'h010B);

    // R4 wrap both ways
    run_op(8'hB4, 8'h01, 8'h05, 16'hFFFE, 8'h02, "R4 wrap up");
    chk(pc_next == 16'h0006, "R4", "wrap up", int'(pc_next), 16'h0006);
    run_op(8'hB4, 8'h01, 8'h80, 16'h0001, 8'h02, "R4 wrap down");
    chk(pc_next == 16'hFF84, "R4", "wrap down", int'(pc_next), 16'hFF84);
    // R5: equal at top of space wraps
    run_op(8'hB4, 8'h33, 8'h80, 16'hFFFF, 8'h33, "R5 wrap");
    chk(pc_next == 16'h0002, "R5", "fall through wrap", int'(pc_next), 16'h0002);

    // R7 and R9: illegal opcodes start nothing, outputs held
    hold_pc = pc_next; hold_c = carry; hold_t = taken;
    foreach (opcode[k]) ;
    for (int o = 0; o < 256; o += 15) begin
      if (o >= 8'hB4 && o <= 8'hBF) continue;
      opcode = 8'(o); b1 = 8'h00; acc = 8'hFF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int w = 0; w < 4; w++) begin
        chk(!busy && !done, "R7", "illegal opcode activity", {busy, done}, 0);
        @(negedge clk);
      end
    end
    chk(pc_next == hold_pc && carry == hold_c && taken == hold_t, "R9", "hold",
        int'(pc_next), int'(hold_pc));

    // R8: start while busy ignored
    mem[0] = 8'h20; mem[8'h20] = 8'h10;
    opcode = 8'hB6; b1 = 8'h20; b2 = 8'h04; pc = 16'h2000; acc = 8'h00; start = 1'b1;
    @(negedge clk);
    opcode = 8'hB4; b1 = 8'h00; b2 = 8'h7F; pc = 16'h5000; acc = 8'h00;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(done == 1'b1, "R8", "done of first op", int'(done), 1);
    chk(pc_next == 16'h2007 && carry == 1'b1, "R8", "result of first op",
        int'(pc_next), 16'h2007);
    for (int w = 0; w < 3; w++) begin
      @(negedge clk);
      chk(!done && !busy, "R8", "second start ignored", {busy, done}, 0);
    end
    chk(pc_next == 16'h2007, "R9", "hold after op", int'(pc_next), 16'h2007);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule